// File: doc/BRIEF.md
# Displacement-Compressed Branch Target Buffer

This block predicts where a taken branch goes without storing a full target address per entry. Each entry keeps the distance from the branch's own address to its target. Most branches jump only a short way, so the main table gives each entry a narrow signed displacement. A branch whose distance is too large for that field sets a "far" mark in its main entry and keeps its wide displacement in a small, fully associative side table. There is a single level of storage and no backing buffer behind it.

The fetch unit presents an address on the lookup port and, one cycle later, receives a hit flag, the stored taken flag and the predicted target, which is the fetch address plus the sign-extended displacement. The branch resolution logic writes through the update port with the branch address, its resolved target and its taken flag. The block chooses the table from the size of the displacement.

Top module: `disp_btb`

## Requirements
- R1: After reset every entry of both tables is invalid, so every lookup returns pr_hit = 0 and pr_taken = 0 until an update writes the entry.
- R2: A lookup presented with lk_valid = 1 produces its result on pr_valid, pr_hit, pr_taken and pr_target exactly one clock later. A cycle with lk_valid = 0 gives pr_valid = 0, pr_hit = 0 and pr_taken = 0 one clock later.
- R3: The main table is direct-mapped on lk_addr[5:0] and tagged with address bits [31:6]. A lookup hits only if the entry is valid and its tag is equal. An update overwrites the entry at its index, which replaces any branch that was stored there with another tag.
- R4: The displacement is up_target - up_addr, taken modulo 2^32. When it lies in [-256, +255], the 9-bit main-table field holds it and no side-table slot is used. The predicted target is then lk_addr plus the sign-extended displacement, and this holds at both ends of the range.
- R5: A displacement outside [-256, +255], for example +256 or -257, goes to the 8-entry side table with a 32-bit displacement. The predicted target is exact, with the addition wrapping modulo 2^32.
- R6: Side-table slots are allocated round-robin, starting at slot 0 after reset. A ninth distinct far branch evicts the first one. After that, a lookup of the evicted branch returns pr_hit = 0 even though its main entry is valid.
- R7: pr_taken is 1 only on a hit whose last update had up_taken = 1. An update with up_taken = 0 still produces a hit, with pr_taken = 0.
- R8: A later update of the same branch address replaces its prediction: a far branch re-updated with a near target predicts the near target, and the reverse holds as well. The side table never holds more than one slot for a given branch address.
- R9: When an update and a lookup reach the same main index in the same cycle, the lookup returns the contents from before the update. The new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| up_valid | input | 1 | Update request |
| up_addr | input | 32 | Resolved branch address |
| up_target | input | 32 | Resolved branch target |
| up_taken | input | 1 | Resolved taken flag |
| pr_valid | output | 1 | Registered lookup result is present |
| pr_hit | output | 1 | Prediction available |
| pr_taken | output | 1 | Predicted taken |
| pr_target | output | 32 | Predicted target address (0 on miss) |

## Verification
A wrong displacement, a wrong far mark or a stale tag shows up as a wrong pr_target or pr_hit on the cycle right after the lookup of that branch. The fault is therefore visible one clock after the first lookup that reads the faulty entry. Side-table bookkeeping errors, such as a wrong round-robin pointer or a near update that takes a slot, are hidden until enough far branches have been allocated to force an eviction. They then appear as a hit where a miss was due, or a miss where a hit was due. The bench therefore mixes boundary displacements into a full round of side-table allocation.

// File: rtl/disp_btb_pkg.sv
package disp_btb_pkg;

    parameter int ADDR_W = 32;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              taken;
        logic [ADDR_W-1:0] target;
    } pred_t;

endpackage

// File: rtl/disp_btb_main.sv
module disp_btb_main
    import disp_btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int DISP_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic              rd_taken,
    output logic              rd_far,
    output logic [DISP_W-1:0] rd_disp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_taken,
    input  logic              wr_far,
    input  logic [DISP_W-1:0] wr_disp
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic              taken;
        logic              far;
        logic [DISP_W-1:0] disp;
    } ment_t;

    ment_t mem_q [ENTRIES];
    ment_t mem_d [ENTRIES];

    logic [IDX_W-1:0] ridx, widx;
    logic [TAG_W-1:0] rtag, wtag;
    ment_t            rent;

    assign ridx = rd_addr[IDX_W-1:0];
    assign rtag = rd_addr[ADDR_W-1:IDX_W];
    assign widx = wr_addr[IDX_W-1:0];
    assign wtag = wr_addr[ADDR_W-1:IDX_W];

    // read uses the current contents: a same-cycle write is seen next cycle
    always_comb begin
        rent     = mem_q[ridx];
        rd_hit   = rent.valid && (rent.tag == rtag);
        rd_taken = rent.taken;
        rd_far   = rent.far;
        rd_disp  = rent.disp;
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[widx].valid = 1'b1;
            mem_d[widx].tag   = wtag;
            mem_d[widx].taken = wr_taken;
            mem_d[widx].far   = wr_far;
            mem_d[widx].disp  = wr_disp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // R3: a written entry holds the writer's tag and is valid afterwards
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(widx)].valid && mem_q[$past(widx)].tag == $past(wtag)));

endmodule

// File: rtl/disp_btb_far.sv
module disp_btb_far
    import disp_btb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int DISP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [DISP_W-1:0] rd_disp,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DISP_W-1:0] wr_disp,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] key;
        logic [DISP_W-1:0] disp;
    } fent_t;

    typedef struct packed {
        fent_t [ENTRIES-1:0] ent;
        logic  [PTR_W-1:0]   rr;
    } fstate_t;

    fstate_t st_q, st_d;

    logic [ENTRIES-1:0] rd_match, wr_match, clr_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign rd_match[g]  = st_q.ent[g].valid && (st_q.ent[g].key == rd_addr);
        assign wr_match[g]  = st_q.ent[g].valid && (st_q.ent[g].key == wr_addr);
        assign clr_match[g] = st_q.ent[g].valid && (st_q.ent[g].key == clr_addr);
    end

    always_comb begin
        rd_hit  = |rd_match;
        rd_disp = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_match[i]) rd_disp = rd_disp | st_q.ent[i].disp;
        end
    end

    always_comb begin
        logic [PTR_W-1:0] slot;
        st_d = st_q;
        slot = st_q.rr;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_match[i]) slot = PTR_W'(i);
        end
        if (wr_en) begin
            st_d.ent[slot].valid = 1'b1;
            st_d.ent[slot].key   = wr_addr;
            st_d.ent[slot].disp  = wr_disp;
            if (!(|wr_match)) begin
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
        if (clr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (clr_match[i]) st_d.ent[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: one slot at most per branch address
    a_r8_key_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match) && $onehot0(wr_match));

    // R6: a fresh allocation moves the round-robin pointer by one slot
    a_r6_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|wr_match)) |=>
            (st_q.rr == (($past(st_q.rr) == LAST) ? '0 : $past(st_q.rr) + 1'b1)));

    // R6: a rewrite or a clear leaves the pointer unchanged
    a_r6_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !(|wr_match)) |=> $stable(st_q.rr));

endmodule

// File: rtl/disp_btb.sv
module disp_btb
    import disp_btb_pkg::*;
#(
    parameter int MAIN_ENTRIES = 64,
    parameter int NEAR_W       = 9,
    parameter int FAR_ENTRIES  = 8,
    parameter int FAR_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              up_taken,
    output logic              pr_valid,
    output logic              pr_hit,
    output logic              pr_taken,
    output logic [ADDR_W-1:0] pr_target
);

    logic [ADDR_W-1:0] up_disp;
    logic              up_fits;
    logic [NEAR_W-1:0] near_wr;

    logic              m_hit, m_taken, m_far;
    logic [NEAR_W-1:0] m_disp;
    logic              f_hit;
    logic [FAR_W-1:0]  f_disp;
    logic [ADDR_W-1:0] sel_disp;

    pred_t pred_d, pred_q;

    // update side: classify the displacement by width
    always_comb begin
        up_disp = up_target - up_addr;
        up_fits = (ADDR_W'($signed(up_disp[NEAR_W-1:0])) == up_disp);
        near_wr = up_fits ? up_disp[NEAR_W-1:0] : '0;
    end

    disp_btb_main #(
        .ENTRIES (MAIN_ENTRIES),
        .DISP_W  (NEAR_W)
    ) main_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (lk_addr),
        .rd_hit   (m_hit),
        .rd_taken (m_taken),
        .rd_far   (m_far),
        .rd_disp  (m_disp),
        .wr_en    (up_valid),
        .wr_addr  (up_addr),
        .wr_taken (up_taken),
        .wr_far   (!up_fits),
        .wr_disp  (near_wr)
    );

    disp_btb_far #(
        .ENTRIES (FAR_ENTRIES),
        .DISP_W  (FAR_W)
    ) far_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (lk_addr),
        .rd_hit   (f_hit),
        .rd_disp  (f_disp),
        .wr_en    (up_valid && !up_fits),
        .wr_addr  (up_addr),
        .wr_disp  (up_disp[FAR_W-1:0]),
        .clr_en   (up_valid && up_fits),
        .clr_addr (up_addr)
    );

    // lookup side: select the displacement and form the target
    always_comb begin
        sel_disp = m_far ? ADDR_W'($signed(f_disp)) : ADDR_W'($signed(m_disp));
        pred_d.valid  = lk_valid;
        pred_d.hit    = lk_valid && m_hit && (!m_far || f_hit);
        pred_d.taken  = pred_d.hit && m_taken;
        pred_d.target = pred_d.hit ? (lk_addr + sel_disp) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pred_q <= '0;
        else        pred_q <= pred_d;
    end

    assign pr_valid  = pred_q.valid;
    assign pr_hit    = pred_q.hit;
    assign pr_taken  = pred_q.taken;
    assign pr_target = pred_q.target;

    // R2: a request yields a result on the next cycle
    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pr_valid);

    // R2: an idle cycle yields nothing on the next cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pr_valid && !pr_hit && !pr_taken));

    // R7: taken only accompanies a hit
    a_r7_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pr_taken |-> (pr_hit && pr_valid));

    // R6: a far main entry whose side slot is missing gives no hit
    a_r6_far_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && m_hit && m_far && !f_hit) |=> !pr_hit);

endmodule

// File: tb/disp_btb_tb_top.sv
`timescale 1ns/1ps
module disp_btb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, up_valid, up_taken;
    logic [31:0] lk_addr, up_addr, up_target;
    logic        pr_valid, pr_hit, pr_taken;
    logic [31:0] pr_target;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    disp_btb dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .up_valid  (up_valid),
        .up_addr   (up_addr),
        .up_target (up_target),
        .up_taken  (up_taken),
        .pr_valid  (pr_valid),
        .pr_hit    (pr_hit),
        .pr_taken  (pr_taken),
        .pr_target (pr_target)
    );

    localparam int NV = 8;
    // near +64, near -256, near +255, far +256, far -257, far wrapping, near not-taken, far large
    localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1004, 32'h0000_2008, 32'h0000_300C, 32'h0000_4010,
                                            32'h0000_5014, 32'hFFFF_FF18, 32'h0000_601C, 32'h1234_5620};
    localparam logic [31:0] V_TGT  [NV] = '{32'h0000_1044, 32'h0000_1F08, 32'h0000_310B, 32'h0000_4110,
                                            32'h0000_4F13, 32'h0000_1018, 32'h0000_6000, 32'h8765_4320};
    localparam logic        V_TKN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [31:0] a, input logic [31:0] t, input logic k);
        @(negedge clk);
        up_valid = 1'b1; up_addr = a; up_target = t; up_taken = k;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] a,
                              input logic [31:0] t, input logic k);
        do_lookup(a);
        chk({req, " valid"}, {31'd0, pr_valid}, 32'd1);
        chk({req, " hit"}, {31'd0, pr_hit}, 32'd1);
        chk({req, " taken"}, {31'd0, pr_taken}, {31'd0, k});
        chk({req, " target"}, pr_target, t);
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a);
        do_lookup(a);
        chk({req, " valid"}, {31'd0, pr_valid}, 32'd1);
        chk({req, " hit"}, {31'd0, pr_hit}, 32'd0);
        chk({req, " taken"}, {31'd0, pr_taken}, 32'd0);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        lk_valid = 0; lk_addr = 0; up_valid = 0; up_addr = 0; up_target = 0; up_taken = 0;
        apply_reset();

        // R1: empty after reset
        expect_miss("R1 reset", V_ADDR[0]);
        expect_miss("R1 reset", V_ADDR[3]);

        // R4 R5 R7: vector table walk, update then look up each branch
        for (int i = 0; i < NV; i++) begin
            do_update(V_ADDR[i], V_TGT[i], V_TKN[i]);
            expect_hit("R4 R5 R7 table", V_ADDR[i], V_TGT[i], V_TKN[i]);
        end

        // R2: idle cycle gives no result
        @(negedge clk);
        @(negedge clk);
        chk("R2 idle valid", {31'd0, pr_valid}, 32'd0);
        chk("R2 idle hit", {31'd0, pr_hit}, 32'd0);

        // R3: same index with a different tag misses, then replaces
        expect_miss("R3 alias", 32'h0000_1044);
        do_update(32'h0000_1044, 32'h0000_1080, 1'b1);
        expect_miss("R3 replaced", 32'h0000_1004);
        expect_hit("R3 new tag", 32'h0000_1044, 32'h0000_1080, 1'b1);

        // R8: far to near, near to far
        do_update(32'h0000_4010, 32'h0000_4020, 1'b1);
        expect_hit("R8 far to near", 32'h0000_4010, 32'h0000_4020, 1'b1);
        do_update(32'h0000_300C, 32'h9000_0000, 1'b1);
        expect_hit("R8 near to far", 32'h0000_300C, 32'h9000_0000, 1'b1);

        // R7: not-taken branch becomes taken
        do_update(V_ADDR[6], V_TGT[6], 1'b1);
        expect_hit("R7 retaken", V_ADDR[6], V_TGT[6], 1'b1);

        // R9: update and lookup on the same index in one cycle
        @(negedge clk);
        up_valid = 1'b1; up_addr = 32'h0000_300C; up_target = 32'h0000_3010; up_taken = 1'b1;
        lk_valid = 1'b1; lk_addr = 32'h0000_300C;
        @(negedge clk);
        up_valid = 1'b0; lk_valid = 1'b0;
        chk("R9 old contents", pr_target, 32'h9000_0000);
        expect_hit("R9 new contents", 32'h0000_300C, 32'h0000_3010, 1'b1);

        // R1: reset clears everything written so far
        apply_reset();
        expect_miss("R1 cleared", V_ADDR[7]);
        expect_miss("R1 cleared", 32'h0000_1044);

        // R6 with R4 bounds: eight far branches fill the side table
        for (int i = 0; i < 8; i++) begin
            do_update(32'h0000_4000 + 32'(i * 4), 32'h0000_5000 + 32'(i * 4), 1'b1);
        end
        // near branches at +255 and -256 take no side slot
        do_update(32'h0000_5028, 32'h0000_5127, 1'b1);
        do_update(32'h0000_502C, 32'h0000_4F2C, 1'b0);
        // ninth far branch evicts slot 0 only
        do_update(32'h0000_4020, 32'h0000_5020, 1'b1);
        expect_miss("R6 evicted", 32'h0000_4000);
        expect_hit("R6 kept", 32'h0000_4004, 32'h0000_5004, 1'b1);
        expect_hit("R6 newest", 32'h0000_4020, 32'h0000_5020, 1'b1);
        expect_hit("R4 max", 32'h0000_5028, 32'h0000_5127, 1'b1);
        expect_hit("R4 min", 32'h0000_502C, 32'h0000_4F2C, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule